// File: doc/BRIEF.md
# Settable BCD Minute Counter

This block keeps a two-digit decimal count from 00 to 59 as two 4-bit BCD digits. Everything runs on one system clock with an asynchronous active-low reset. When counting is enabled, a one-cycle tick moves the count one step up or down, according to a direction input. Whenever the count wraps, from 59 to 00 or from 00 to 59, a carry output changes level. A following stage can treat each change of that level as one event.

Two push-button inputs let a user set the time. One advances only the units digit and the other advances only the tens digit. The buttons are never used as clocks. Each one passes through a synchronizer and a rising-edge detector that run on the system clock, so a press acts once no matter how long it is held. Debouncing, display decoding and the mode control that decides when buttons are allowed all sit outside this block.

Top module: `mincnt_top`

## Requirements
- R1: The units digit `units_bcd` always holds a plain binary value from 0 to 9. The tens digit `tens_bcd` always holds a value from 0 to 5. Each is 4 bits wide.
- R2: When `run_en`=1, `tick`=1 and `count_up`=1 at a rising clock edge, and no button edge is pending, the count advances by one at that edge. A units digit of 9 becomes 0 and the tens digit increments, and 59 becomes 00.
- R3: When `run_en`=1, `tick`=1 and `count_up`=0 at a rising edge, and no button edge is pending, the count decreases by one at that edge. A units digit of 0 becomes 9 and the tens digit decrements, and 00 becomes 59.
- R4: `carry_tgl` inverts at the same edge as each 59-to-00 or 00-to-59 count step. It stays unchanged at every other edge.
- R5: While `rst_n`=0, without waiting for a clock edge, both digits and `carry_tgl` are 0.
- R6: At an edge where `run_en`=0 or `tick`=0, and no button edge is pending, both digits and the carry keep their values.
- R7: A rising level on `units_btn` adds one to the units digit, wrapping 9 to 0. It changes neither the tens digit nor `carry_tgl`. The change appears at the third rising clock edge that samples the button high: two synchronizer stages, then the update.
- R8: A rising level on `tens_btn` adds one to the tens digit, wrapping 5 to 0. It changes neither the units digit nor `carry_tgl`. It has the same latency as R7.
- R9: A button held high for many cycles acts exactly once. A button that is already high while reset is asserted does not act after reset is released.
- R10: When events meet at the same edge, the units-button edge wins over the tens-button edge, and the tens-button edge wins over a count tick. The events that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Counting enable level |
| tick | input | 1 | One-cycle count request |
| count_up | input | 1 | 1 = count up, 0 = count down |
| units_btn | input | 1 | Asynchronous button, advance units digit |
| tens_btn | input | 1 | Asynchronous button, advance tens digit |
| units_bcd | output | 4 | Units digit, BCD |
| tens_bcd | output | 4 | Tens digit, BCD |
| carry_tgl | output | 1 | Level that inverts on every wrap |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, digit limits of 9 and 5, and 4-bit digits. With a period of 60 counts, more than two full revolutions in each direction fit easily into a run, so every digit transition and every wrap-driven carry inversion is compared against an arithmetic model of the count. Because the button latency is fixed at three edges, the bench can line up a tick, a units edge and a tens edge on the same clock edge, which puts the priority rules within reach. It also holds a button through reset to check that the press is suppressed.

// File: rtl/mincnt_pkg.sv
package mincnt_pkg;

    // Which single action the counter takes at a clock edge
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_UNITS = 2'd1,
        ACT_TENS  = 2'd2,
        ACT_COUNT = 2'd3
    } act_e;

    localparam int unsigned BTN_UNITS = 0;
    localparam int unsigned BTN_TENS  = 1;
    localparam int unsigned NUM_BTN   = 2;

endpackage

// File: rtl/mincnt_btn_edge.sv
module mincnt_btn_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic rise_o
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } edge_st_t;

    edge_st_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.sync = {state_q.sync[STAGES-2:0], btn_i};
        state_d.last = state_q.sync[TOP];
    end

    // Reset fills the history with ones so a level held through reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sync <= '1;
            state_q.last <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign rise_o = state_q.sync[TOP] & ~state_q.last;

    // R9: an edge lasts exactly one cycle
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/mincnt_digit.sv
module mincnt_digit #(
    parameter int unsigned W    = 4,
    parameter int unsigned MAXV = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_i,
    input  logic         down_i,
    output logic [W-1:0] val_o,
    output logic         at_max_o,
    output logic         at_min_o
);

    localparam logic [W-1:0] LIM  = W'(MAXV);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] val;
    } dig_st_t;

    dig_st_t dig_d, dig_q;

    always_comb begin
        dig_d = dig_q;
        if (up_i) begin
            dig_d.val = (dig_q.val == LIM) ? ZERO : dig_q.val + ONE;
        end else if (down_i) begin
            dig_d.val = (dig_q.val == ZERO) ? LIM : dig_q.val - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_q.val <= ZERO;
        end else begin
            dig_q <= dig_d;
        end
    end

    assign val_o    = dig_q.val;
    assign at_max_o = (dig_q.val == LIM);
    assign at_min_o = (dig_q.val == ZERO);

    // R1: digit never leaves its decimal range
    assert_digit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        val_o <= LIM);

    // R6: no request keeps the digit
    assert_digit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_i && !down_i) |=> $stable(val_o));

endmodule

// File: rtl/mincnt_top.sv
module mincnt_top #(
    parameter int unsigned DIG_W      = 4,
    parameter int unsigned UNITS_MAX  = 9,
    parameter int unsigned TENS_MAX   = 5,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic             count_up,
    input  logic             units_btn,
    input  logic             tens_btn,
    output logic [DIG_W-1:0] units_bcd,
    output logic [DIG_W-1:0] tens_bcd,
    output logic             carry_tgl
);
    import mincnt_pkg::*;

    localparam logic [DIG_W-1:0] U_LIM = DIG_W'(UNITS_MAX);
    localparam logic [DIG_W-1:0] T_LIM = DIG_W'(TENS_MAX);

    logic [NUM_BTN-1:0] btn_vec;
    logic [NUM_BTN-1:0] rise_vec;

    assign btn_vec[BTN_UNITS] = units_btn;
    assign btn_vec[BTN_TENS]  = tens_btn;

    for (genvar gi = 0; gi < NUM_BTN; gi++) begin : g_btn
        mincnt_btn_edge #(.STAGES(SYNC_DEPTH)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .btn_i  (btn_vec[gi]),
            .rise_o (rise_vec[gi])
        );
    end

    typedef struct packed {
        logic carry;
    } top_st_t;

    top_st_t top_d, top_q;
    act_e    act;
    logic    u_up, u_dn, t_up, t_dn, wrap;
    logic    u_max, u_min, t_max, t_min;

    always_comb begin
        if (rise_vec[BTN_UNITS]) begin
            act = ACT_UNITS;
        end else if (rise_vec[BTN_TENS]) begin
            act = ACT_TENS;
        end else if (run_en && tick) begin
            act = ACT_COUNT;
        end else begin
            act = ACT_NONE;
        end

        u_up = (act == ACT_UNITS) || ((act == ACT_COUNT) && count_up);
        u_dn = (act == ACT_COUNT) && !count_up;
        t_up = (act == ACT_TENS)  || ((act == ACT_COUNT) && count_up && u_max);
        t_dn = (act == ACT_COUNT) && !count_up && u_min;
        wrap = (act == ACT_COUNT) &&
               (count_up ? (u_max && t_max) : (u_min && t_min));

        top_d       = top_q;
        top_d.carry = top_q.carry ^ wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.carry <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    mincnt_digit #(.W(DIG_W), .MAXV(UNITS_MAX)) u_units (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (u_up),
        .down_i   (u_dn),
        .val_o    (units_bcd),
        .at_max_o (u_max),
        .at_min_o (u_min)
    );

    mincnt_digit #(.W(DIG_W), .MAXV(TENS_MAX)) u_tens (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_i     (t_up),
        .down_i   (t_dn),
        .val_o    (tens_bcd),
        .at_max_o (t_max),
        .at_min_o (t_min)
    );

    assign carry_tgl = top_q.carry;

    // R2: top of range wraps to zero and flips the carry
    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && count_up && rise_vec == '0 &&
         units_bcd == U_LIM && tens_bcd == T_LIM)
        |=> (units_bcd == '0 && tens_bcd == '0 && carry_tgl != $past(carry_tgl)));

    // R3: zero wraps to top of range and flips the carry
    assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && tick && !count_up && rise_vec == '0 &&
         units_bcd == '0 && tens_bcd == '0)
        |=> (units_bcd == U_LIM && tens_bcd == T_LIM && carry_tgl != $past(carry_tgl)));

    // R6: idle edges keep everything
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!run_en || !tick) && rise_vec == '0)
        |=> ($stable(units_bcd) && $stable(tens_bcd) && $stable(carry_tgl)));

    // R7: units button leaves tens and carry alone
    assert_units_btn_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise_vec[BTN_UNITS] |=> ($stable(tens_bcd) && $stable(carry_tgl)));

    // R8: tens button leaves units and carry alone
    assert_tens_btn_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vec[BTN_TENS] && !rise_vec[BTN_UNITS])
        |=> ($stable(units_bcd) && $stable(carry_tgl)));

    // R4: carry never flips except on a count step
    assert_carry_only_on_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run_en && tick) || rise_vec != '0) |=> $stable(carry_tgl));

endmodule

// File: tb/mincnt_top_bench.sv
module mincnt_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, tick = 1'b0, count_up = 1'b1;
    logic       units_btn = 1'b0, tens_btn = 1'b0;
    logic [3:0] units_bcd, tens_bcd;
    logic       carry_tgl;

    int n_cmp = 0;
    int n_bad = 0;
    int val   = 0;
    int carry = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mincnt_top u_mincnt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (tick),
        .count_up  (count_up),
        .units_btn (units_btn),
        .tens_btn  (tens_btn),
        .units_bcd (units_bcd),
        .tens_bcd  (tens_bcd),
        .carry_tgl (carry_tgl)
    );

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " units"}, int'(units_bcd), val % 10);
        check({req, " tens"},  int'(tens_bcd),  val / 10);
        check({req, " carry"}, int'(carry_tgl), carry);
    endtask

    task automatic do_tick(input string req);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        if (run_en) begin
            if (count_up) begin
                if (val == 59) carry ^= 1;
                val = (val + 1) % 60;
            end else begin
                if (val == 0) carry ^= 1;
                val = (val + 59) % 60;
            end
        end
        check_all(req);
    endtask

    // which: 0 units, 1 tens
    task automatic press(input int which, input string req);
        @(negedge clk);
        if (which == 0) units_btn = 1'b1; else tens_btn = 1'b1;
        repeat (8) @(negedge clk);
        units_btn = 1'b0;
        tens_btn  = 1'b0;
        repeat (4) @(negedge clk);
        if (which == 0) val = (val / 10) * 10 + ((val % 10) + 1) % 10;
        else            val = (((val / 10) + 1) % 6) * 10 + val % 10;
        check_all(req);
    endtask

    // Button edge and a tick land on the same clock edge (three edges after the press)
    task automatic clash(input bit u, input bit t, input bit tk, input string req);
        @(negedge clk);
        units_btn = u;
        tens_btn  = t;
        @(negedge clk);
        @(negedge clk) tick = tk;
        @(negedge clk) tick = 1'b0;
        units_btn = 1'b0;
        tens_btn  = 1'b0;
        if (u)      val = (val / 10) * 10 + ((val % 10) + 1) % 10;
        else if (t) val = (((val / 10) + 1) % 6) * 10 + val % 10;
        check_all(req);
        repeat (4) @(negedge clk);
        check_all({req, " settle"});
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R5 reset state
        repeat (3) @(negedge clk);
        check_all("R5 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 and R4 upward sweep over two revolutions
        run_en = 1'b1;
        count_up = 1'b1;
        for (int i = 0; i < 125; i++) do_tick("R2 up");
        check("R4 carry after two up wraps", int'(carry_tgl), 0);

        // R6 disabled counting and absent tick
        run_en = 1'b0;
        for (int i = 0; i < 5; i++) do_tick("R6 disabled");
        run_en = 1'b1;
        repeat (6) @(negedge clk);
        check_all("R6 no tick");

        // R3 and R4 downward sweep
        count_up = 1'b0;
        for (int i = 0; i < 130; i++) do_tick("R3 down");

        // R7 units button, incl. 9->0 wrap; held presses act once (R9)
        run_en = 1'b0;
        for (int i = 0; i < 12; i++) press(0, "R7 units button");
        // R8 tens button, incl. 5->0 wrap
        for (int i = 0; i < 8; i++) press(1, "R8 tens button");

        // R10 priority
        run_en = 1'b1;
        count_up = 1'b1;
        clash(1'b1, 1'b0, 1'b1, "R10 units beats tick");
        clash(1'b0, 1'b1, 1'b1, "R10 tens beats tick");
        clash(1'b1, 1'b1, 1'b0, "R10 units beats tens");
        clash(1'b1, 1'b1, 1'b1, "R10 units beats all");

        // R5 asynchronous clear mid-cycle with carry set
        run_en = 1'b1;
        count_up = 1'b0;
        while (carry == 0) do_tick("R4 reach carry");
        @(negedge clk);
        #3 rst_n = 1'b0;
        #2;
        val = 0;
        carry = 0;
        check_all("R5 async clear");

        // R9 button held through reset does not act
        units_btn = 1'b1;
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check_all("R9 held through reset");
        units_btn = 1'b0;
        repeat (4) @(negedge clk);
        press(0, "R9 press after reset");

        finish_run();
    end

endmodule